// File: doc/BRIEF.md
# Monitor Channel Transmit Stall Supervisor

This block watches the transmit side of a byte-serial handshake channel that travels inside a framed time-division serial bus. It counts whole bus frames while the transmitter is stalled. The transmitter can stall in two ways: it can wait for the addressed device to acknowledge, or it can wait for the microcontroller to supply the next byte. If the stall lasts a configured number of frames, the block breaks the deadlock. It forces the channel's MX bit high for two consecutive frames, which is the end-of-message signal, and it raises a single-cycle abort pulse.

The surrounding handshake logic supplies a frame strobe, the two wait indications, a progress pulse and its own MX value. Outside an abort, MX passes through unchanged. Supervision is active only while the time-out enable bit is set.

Top module: `mon_tx_watchdog`

## Requirements
- R1: After reset `abort_o` is 0 and `mx_o` equals `mx_hs_i`.
- R2: While enabled and `wait_ack_i` is 1, a frame strobe (`frame_i` high for one cycle) that arrives with no progress is counted. `abort_o` goes high in the cycle after the posedge of the 40th counted strobe.
- R3: A stall with `wait_data_i` high (alone or together with `wait_ack_i`) is timed in the same way as in R2.
- R4: A `progress_i` pulse clears the count, including in a strobe cycle; that strobe is not counted. The next abort then needs 40 further counted strobes.
- R5: While `tout_en_i` is 0 the count is held at zero and no abort is raised. After re-enabling, a full 40 strobes are needed.
- R6: A strobe that arrives while neither wait input is high clears the count.
- R7: `abort_o` is high for exactly one clock cycle for each expiry.
- R8: From the cycle after the expiring strobe, `mx_o` is forced to 1. It stays forced through the next two frame strobes, so it reads 1 at both of them, and it returns to `mx_hs_i` in the cycle after the second one.
- R9: During the two-frame end-of-message sequence, strobes are not counted and no new abort can start. Counting resumes from zero after the sequence.
- R10: Outside the end-of-message sequence, `mx_o` follows `mx_hs_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle strobe at each bus frame |
| tout_en_i | input | 1 | Time-out supervision enable |
| wait_ack_i | input | 1 | Transmitter waits for the remote acknowledge |
| wait_data_i | input | 1 | Transmitter waits for new data from the microcontroller |
| progress_i | input | 1 | Reply received or new data written |
| mx_hs_i | input | 1 | MX value from the normal handshake logic |
| mx_o | output | 1 | MX bit driven onto the bus |
| abort_o | output | 1 | One-cycle pulse when an end-of-message abort starts |

## Verification
The hardest behaviour to reach from the ports is what happens after an abort: the sequence must not retrigger, and counting must restart cleanly. Observing this needs a full 40-frame stall, with the wait input still held high through the end-of-message frames. The bench holds the stall through both end-of-message frames. It checks the MX value at each strobe and in the cycle after each strobe. It then counts strobes until the second abort and expects exactly 40 more.

// File: rtl/mon_tx_wd_pkg.sv
package mon_tx_wd_pkg;
    localparam int unsigned STALL_FRAMES_DEF = 40;
    localparam int unsigned EOM_FRAMES_DEF   = 2;
endpackage

// File: rtl/mon_tx_wd_timer.sv
module mon_tx_wd_timer #(
    parameter int unsigned LIMIT = 40,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          run_i,
    input  logic          clr_i,
    output logic          expire_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!run_i || clr_i) begin
            st_d.cnt = '0;
        end else if (frame_i) begin
            if (st_q.cnt == CW'(LIMIT - 1)) begin
                expire_o = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/mon_tx_wd_eom.sv
module mon_tx_wd_eom #(
    parameter int unsigned EOM_FRAMES = 2,
    localparam int unsigned EW        = $clog2(EOM_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic start_i,
    output logic active_o,
    output logic pulse_o
);
    typedef struct packed {
        logic          active;
        logic [EW-1:0] fcnt;
        logic          pulse;
    } eom_t;

    eom_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.fcnt   = '0;
                st_d.pulse  = 1'b1;
            end
        end else if (frame_i) begin
            if (st_q.fcnt == EW'(EOM_FRAMES - 1)) begin
                st_d.active = 1'b0;
                st_d.fcnt   = '0;
            end else begin
                st_d.fcnt = st_q.fcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign pulse_o  = st_q.pulse;
endmodule

// File: rtl/mon_tx_watchdog.sv
module mon_tx_watchdog
    import mon_tx_wd_pkg::*;
#(
    parameter int unsigned STALL_FRAMES = STALL_FRAMES_DEF,
    parameter int unsigned EOM_FRAMES   = EOM_FRAMES_DEF,
    localparam int unsigned CW          = $clog2(STALL_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic tout_en_i,
    input  logic wait_ack_i,
    input  logic wait_data_i,
    input  logic progress_i,
    input  logic mx_hs_i,
    output logic mx_o,
    output logic abort_o
);
    logic          eom_active;
    logic          stall_run;
    logic          expire;
    logic [CW-1:0] tmr_count;

    // Counting pauses during end-of-message so an abort cannot retrigger.
    assign stall_run = tout_en_i && (wait_ack_i || wait_data_i) && !eom_active;

    mon_tx_wd_timer #(.LIMIT(STALL_FRAMES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame_i),
        .run_i    (stall_run),
        .clr_i    (progress_i),
        .expire_o (expire),
        .count_o  (tmr_count)
    );

    mon_tx_wd_eom #(.EOM_FRAMES(EOM_FRAMES)) u_eom (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame_i),
        .start_i  (expire),
        .active_o (eom_active),
        .pulse_o  (abort_o)
    );

    assign mx_o = eom_active | mx_hs_i;
endmodule

// File: rtl/mon_tx_watchdog_chk.sv
module mon_tx_watchdog_chk #(
    parameter int unsigned STALL_FRAMES = 40,
    parameter int unsigned CW           = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tout_en_i,
    input logic          progress_i,
    input logic          mx_o,
    input logic          abort_o,
    input logic          eom_active,
    input logic [CW-1:0] tmr_count
);
    p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    p_abort_starts_eom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> eom_active);

    p_mx_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eom_active |-> mx_o);

    p_count_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_en_i |=> (tmr_count == '0));

    p_progress_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        progress_i |=> (tmr_count == '0));

    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eom_active |=> (tmr_count == '0) && !abort_o);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_count < CW'(STALL_FRAMES));
endmodule

bind mon_tx_watchdog mon_tx_watchdog_chk #(.STALL_FRAMES(STALL_FRAMES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tout_en_i  (tout_en_i),
    .progress_i (progress_i),
    .mx_o       (mx_o),
    .abort_o    (abort_o),
    .eom_active (eom_active),
    .tmr_count  (tmr_count)
);

// File: tb/mon_tx_watchdog_test.sv
module mon_tx_watchdog_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV         = 7;
    localparam int  RUN_TICKS  = 80;

    // {en, wait_ack, wait_data, progress_at_tick[6:0], expected_abort_tick[6:0]}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 7'd0,  7'd40},  // R2
        {1'b1, 1'b0, 1'b1, 7'd0,  7'd40},  // R3
        {1'b1, 1'b1, 1'b1, 7'd0,  7'd40},  // R3
        {1'b1, 1'b1, 1'b0, 7'd25, 7'd65},  // R4
        {1'b0, 1'b1, 1'b0, 7'd0,  7'd0},   // R5
        {1'b1, 1'b0, 1'b0, 7'd0,  7'd0},   // R6
        {1'b1, 1'b0, 1'b1, 7'd39, 7'd79}   // R4
    };

    logic clk = 1'b0;
    logic rst_n, frame_i, tout_en_i, wait_ack_i, wait_data_i, progress_i, mx_hs_i;
    logic mx_o, abort_o;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_tx_watchdog uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .tout_en_i(tout_en_i),
        .wait_ack_i(wait_ack_i), .wait_data_i(wait_data_i), .progress_i(progress_i),
        .mx_hs_i(mx_hs_i), .mx_o(mx_o), .abort_o(abort_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_i = 1'b0; tout_en_i = 1'b0; wait_ack_i = 1'b0;
        wait_data_i = 1'b0; progress_i = 1'b0; mx_hs_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One frame: strobe cycle, then gap. Reports MX during the strobe,
    // abort and MX just after the strobe edge, and abort one cycle later.
    task automatic tick(input bit prog, output logic mx_at, output logic ab,
                        output logic mx_after, output logic ab_late);
        @(negedge clk);
        frame_i = 1'b1; progress_i = prog;
        #1 mx_at = mx_o;
        @(negedge clk);
        frame_i = 1'b0; progress_i = 1'b0;
        ab = abort_o; mx_after = mx_o;
        @(negedge clk);
        ab_late = abort_o;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic m1, a1, m2, a2;
        int   first;
        // R1 / R10: reset state and pass-through
        do_reset();
        check(abort_o == 1'b0, "R1", abort_o, 0);
        check(mx_o == 1'b0, "R1", mx_o, 0);
        mx_hs_i = 1'b1; #1;
        check(mx_o == 1'b1, "R10", mx_o, 1);
        mx_hs_i = 1'b0; #1;
        check(mx_o == 1'b0, "R10", mx_o, 0);

        // Vector table: strobe index of first abort
        for (int v = 0; v < NV; v++) begin
            do_reset();
            tout_en_i = VEC[v][16]; wait_ack_i = VEC[v][15]; wait_data_i = VEC[v][14];
            first = 0;
            for (int t = 1; t <= RUN_TICKS; t++) begin
                tick(int'(VEC[v][13:7]) == t, m1, a1, m2, a2);
                if (a1 && first == 0) first = t;
            end
            check(first == int'(VEC[v][6:0]), $sformatf("R%0s vec%0d",
                  v == 0 ? "2" : (v < 3 ? "3" : (v == 4 ? "5" : (v == 5 ? "6" : "4"))), v),
                  first, int'(VEC[v][6:0]));
        end

        // R7 / R8 / R9: end-of-message shape and no retrigger
        do_reset();
        tout_en_i = 1'b1; wait_ack_i = 1'b1; mx_hs_i = 1'b0;
        for (int t = 1; t < 40; t++) tick(1'b0, m1, a1, m2, a2);
        tick(1'b0, m1, a1, m2, a2);
        check(a1 == 1'b1, "R2 expiry", a1, 1);
        check(a2 == 1'b0, "R7 width", a2, 0);
        check(m2 == 1'b1, "R8 forced", m2, 1);
        tick(1'b0, m1, a1, m2, a2);
        check(m1 == 1'b1, "R8 first frame", m1, 1);
        check(m2 == 1'b1 && a1 == 1'b0, "R9 hold", m2, 1);
        tick(1'b0, m1, a1, m2, a2);
        check(m1 == 1'b1, "R8 second frame", m1, 1);
        check(m2 == 1'b0, "R8 release", m2, 0);
        first = 0;
        for (int t = 1; t <= 45; t++) begin
            tick(1'b0, m1, a1, m2, a2);
            if (a1 && first == 0) first = t;
        end
        check(first == 40, "R9 restart", first, 40);

        // R5: disable mid-stall resets count
        do_reset();
        tout_en_i = 1'b1; wait_ack_i = 1'b1;
        for (int t = 1; t <= 30; t++) tick(1'b0, m1, a1, m2, a2);
        tout_en_i = 1'b0;
        first = 0;
        for (int t = 1; t <= 15; t++) begin
            tick(1'b0, m1, a1, m2, a2);
            if (a1) first = t;
        end
        check(first == 0, "R5 disabled", first, 0);
        tout_en_i = 1'b1;
        first = 0;
        for (int t = 1; t <= 42; t++) begin
            tick(1'b0, m1, a1, m2, a2);
            if (a1 && first == 0) first = t;
        end
        check(first == 40, "R5 reenable", first, 40);

        // R6: wait drop mid-stall resets count
        do_reset();
        tout_en_i = 1'b1; wait_data_i = 1'b1;
        for (int t = 1; t <= 30; t++) tick(1'b0, m1, a1, m2, a2);
        wait_data_i = 1'b0;
        for (int t = 1; t <= 3; t++) tick(1'b0, m1, a1, m2, a2);
        wait_data_i = 1'b1;
        first = 0;
        for (int t = 1; t <= 42; t++) begin
            tick(1'b0, m1, a1, m2, a2);
            if (a1 && first == 0) first = t;
        end
        check(first == 40, "R6 rewait", first, 40);

        // R10: pass-through while counting
        mx_hs_i = 1'b1;
        tick(1'b0, m1, a1, m2, a2);
        check(m1 == 1'b1 && m2 == 1'b1, "R10 high", m2, 1);
        mx_hs_i = 1'b0;
        for (int t = 1; t <= 3; t++) tick(1'b0, m1, a1, m2, a2);
        check(m1 == 1'b0 && m2 == 1'b0, "R10 low", m2, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule